// File: doc/BRIEF.md
# Serial Byte Receiver with Two-Byte Holding Queue and Ready-to-Send Output

This block receives asynchronous serial frames made of one start bit, eight data bits sent least significant bit first, and one stop bit. The line is sampled with a 16x oversampling tick derived from the core clock by a divider parameter. A receive shift register assembles each frame. At the stop bit it moves the byte into a two-entry first-in first-out holding queue, which the host drains with a pop strobe.

Up to three words can be in flight at once: two in the queue and one in the shift register. If the queue is still full when another stop bit arrives, the new byte is dropped and a sticky overrun flag is raised. The host clears this flag with a one-cycle clear pulse. To keep the remote sender from reaching that point, the active-low ready-to-send output goes inactive (high) as soon as any byte is held. It returns low once the queue is empty again. A host that drains the queue within three frame times never loses data. A stop bit sampled low marks the byte with a framing-error flag, and the byte is still stored.

Top module: `uart_rx_fc`

## Requirements
- R1: With the line idle high, a frame of one low start bit, eight data bits sent least significant bit first and one high stop bit places the byte on rd_data with rd_valid high and rd_ferr low.
- R2: The start bit is confirmed at its middle (8 oversample ticks). A low pulse shorter than half a bit period starts no frame and stores nothing.
- R3: The queue holds two bytes and presents them in arrival order. A pop removes the head entry, and a pop while rd_valid is low has no effect.
- R4: When a stop bit arrives while both entries are held and no pop occurs in that cycle, the new byte is discarded, ovr_err goes high, and the held bytes stay unchanged.
- R5: ovr_err stays high until a clr_ovr pulse clears it. A new overrun in the same cycle takes precedence over the clear.
- R6: A stop bit sampled low stores the byte with rd_ferr high for that entry.
- R7: rts_n is registered and equals the previous cycle's rd_valid. It goes high one cycle after a byte is held and returns low one cycle after the queue empties.
- R8: After reset, rd_valid is low, ovr_err is low and rts_n is low (ready).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| pop | input | 1 | Host strobe that removes the head byte |
| clr_ovr | input | 1 | One-cycle pulse that clears the overrun flag |
| rd_data | output | 8 | Head byte of the holding queue |
| rd_ferr | output | 1 | Framing-error flag of the head byte |
| rd_valid | output | 1 | Queue holds at least one byte |
| ovr_err | output | 1 | Sticky overrun flag |
| rts_n | output | 1 | Active-low ready-to-send to the remote sender |

## Verification
A wrong bit counter or sampling phase appears at rd_data as a shifted or mis-sampled byte as soon as the frame's stop bit is taken. A wrong start qualifier shows up as a byte stored after a short glitch. A corrupted queue pointer or count shows within one pop as bytes out of order, a phantom rd_valid, or an overrun that fires with room left or stays silent on the third unread frame. Flow-control faults appear exactly one cycle after the queue fills or empties, because rts_n must mirror the previous cycle's rd_valid.

// File: rtl/uart_rx_pkg.sv
// Shared types for the serial receiver.
package uart_rx_pkg;
    // Receive state machine phases.
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

    // One held entry: framing flag plus data byte.
    typedef struct packed {
        logic       ferr;
        logic [7:0] data;
    } rx_entry_t;
endpackage

// File: rtl/rx_tick_gen.sv
// Oversample tick generator.
// Emits a one-cycle tick every DIV core clocks. Assumes DIV >= 2.
module rx_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(DIV);

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rx_frame.sv
// Frame assembler: synchronises the line, qualifies the start bit at mid-bit,
// samples each data bit and the stop bit at the centre of its OS ticks and
// shifts data in LSB first. Emits a one-cycle done pulse with the byte.
// Assumes tick is a single-cycle pulse at OS times the bit rate.
module rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OS    = 16,
    parameter int DBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rxd,
    output logic             done,
    output logic [DBITS-1:0] data,
    output logic             ferr
);
    localparam int OW  = $clog2(OS);
    localparam int BW  = $clog2(DBITS);
    localparam int MID = OS / 2 - 1;

    logic [1:0]       sync;
    logic             rx;
    rx_state_t        state;
    logic [OW-1:0]    os_cnt;
    logic [BW-1:0]    bit_idx;
    logic [DBITS-1:0] shreg;

    assign rx = sync[1];

    // Two-stage synchroniser, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    // Frame state machine, oversample counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            os_cnt  <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            done    <= 1'b0;
            data    <= '0;
            ferr    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (state)
                    RX_IDLE: begin
                        os_cnt <= '0;
                        if (!rx) state <= RX_START;
                    end
                    RX_START: begin
                        if (os_cnt == OW'(MID)) begin
                            os_cnt  <= '0;
                            bit_idx <= '0;
                            state   <= rx ? RX_IDLE : RX_DATA;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (os_cnt == OW'(OS - 1)) begin
                            os_cnt <= '0;
                            shreg  <= {rx, shreg[DBITS-1:1]};
                            if (bit_idx == BW'(DBITS - 1)) state <= RX_STOP;
                            else bit_idx <= bit_idx + 1'b1;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (os_cnt == OW'(OS - 1)) begin
                            os_cnt <= '0;
                            done   <= 1'b1;
                            data   <= shreg;
                            ferr   <= ~rx;
                            state  <= RX_IDLE;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_hold_fifo.sv
// Holding queue of DEPTH entries. A push when full is accepted only if a pop
// frees the head in the same cycle; otherwise it is dropped and flagged.
// A pop when empty is ignored. Assumes DEPTH >= 2.
module rx_hold_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t wr_entry,
    input  logic      pop,
    output rx_entry_t rd_entry,
    output logic      not_empty,
    output logic      full,
    output logic      drop
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          pop_ok, push_ok;

    assign not_empty = (count != '0);
    assign full      = (count == CW'(DEPTH));
    assign pop_ok    = pop && not_empty;
    assign push_ok   = push && (!full || pop_ok);
    assign drop      = push && !push_ok;
    assign rd_entry  = mem[rd_ptr];

    // Entry storage written on accepted push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push_ok) begin
            mem[wr_ptr] <= wr_entry;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end
endmodule

// File: rtl/uart_rx_fc.sv
// Serial receiver top: tick divider, frame assembler, two-entry holding queue,
// sticky overrun flag and registered active-low ready-to-send output.
// Assumes rxd idles high and CLK_DIV >= 2.
module uart_rx_fc
    import uart_rx_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int OS      = 16,
    parameter int DEPTH   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       pop,
    input  logic       clr_ovr,
    output logic [7:0] rd_data,
    output logic       rd_ferr,
    output logic       rd_valid,
    output logic       ovr_err,
    output logic       rts_n
);
    logic       tick;
    logic       byte_done;
    logic [7:0] byte_data;
    logic       byte_ferr;
    logic       hold_full;
    logic       hold_drop;
    rx_entry_t  head;

    rx_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    rx_frame #(.OS(OS), .DBITS(8)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .done(byte_done), .data(byte_data), .ferr(byte_ferr)
    );

    rx_hold_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(byte_done), .wr_entry('{ferr: byte_ferr, data: byte_data}),
        .pop(pop), .rd_entry(head), .not_empty(rd_valid),
        .full(hold_full), .drop(hold_drop)
    );

    assign rd_data = head.data;
    assign rd_ferr = head.ferr;

    // Sticky overrun flag; a new drop wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         ovr_err <= 1'b0;
        else if (hold_drop) ovr_err <= 1'b1;
        else if (clr_ovr)   ovr_err <= 1'b0;
    end

    // Flow control: not ready while any byte is held, one cycle late.
    always_ff @(posedge clk) begin
        if (!rst_n) rts_n <= 1'b0;
        else        rts_n <= rd_valid;
    end
endmodule

// File: rtl/uart_rx_fc_chk.sv
// Property checker for uart_rx_fc, attached by bind.
module uart_rx_fc_chk (
    input logic clk,
    input logic rst_n,
    input logic pop,
    input logic clr_ovr,
    input logic rd_valid,
    input logic ovr_err,
    input logic rts_n,
    input logic push,
    input logic full
);
    // R7: rts_n mirrors the previous cycle's occupancy.
    a_r7_rts_lag: assert property (@(posedge clk) disable iff (!rst_n)
        rts_n == $past(rd_valid));

    // R5: overrun flag holds without a clear.
    a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_err && !clr_ovr |=> ovr_err);

    // R4: an unserved push into a full queue raises overrun.
    a_r4_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop |=> ovr_err);

    // R3: popping an empty queue with no push keeps it empty.
    a_r3_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid && pop && !push |=> !rd_valid);

    // R4: a full queue without pop stays non-empty.
    a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop |=> rd_valid);
endmodule

bind uart_rx_fc uart_rx_fc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pop(pop), .clr_ovr(clr_ovr),
    .rd_valid(rd_valid), .ovr_err(ovr_err), .rts_n(rts_n),
    .push(byte_done), .full(hold_full)
);

// File: tb/test_uart_rx_fc.sv
// Directed bench for uart_rx_fc.
module test_uart_rx_fc;
    localparam int CLK_DIV = 4;
    localparam int BIT     = 16 * CLK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       pop = 1'b0;
    logic       clr_ovr = 1'b0;
    logic [7:0] rd_data;
    logic       rd_ferr, rd_valid, ovr_err, rts_n;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    uart_rx_fc #(.CLK_DIV(CLK_DIV)) i_uart_rx_fc (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .pop(pop), .clr_ovr(clr_ovr),
        .rd_data(rd_data), .rd_ferr(rd_ferr), .rd_valid(rd_valid),
        .ovr_err(ovr_err), .rts_n(rts_n)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic stop);
        @(negedge clk) rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BIT) @(negedge clk);
        end
        rxd = stop;
        repeat (BIT) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic do_pop();
        @(negedge clk) pop = 1'b1;
        @(negedge clk) pop = 1'b0;
    endtask

    task automatic t_reset();
        check("R8 valid", rd_valid, 0);
        check("R8 ovr", ovr_err, 0);
        check("R8 rts", rts_n, 0);
    endtask

    task automatic t_single();
        send(8'hA5, 1'b1);
        check("R1 valid", rd_valid, 1);
        check("R1 data", rd_data, 8'hA5);
        check("R1 ferr", rd_ferr, 0);
        check("R7 rts high", rts_n, 1);
        @(negedge clk) pop = 1'b1;
        @(negedge clk) pop = 1'b0;
        check("R7 rts one cycle late", rts_n, 1);
        check("R3 empty after pop", rd_valid, 0);
        @(negedge clk);
        check("R7 rts low", rts_n, 0);
    endtask

    task automatic t_order();
        send(8'h3C, 1'b1);
        send(8'h81, 1'b1);
        check("R3 head first", rd_data, 8'h3C);
        do_pop();
        check("R3 head second", rd_data, 8'h81);
        do_pop();
        check("R3 drained", rd_valid, 0);
    endtask

    task automatic t_overrun();
        send(8'h11, 1'b1);
        send(8'h22, 1'b1);
        check("R4 no ovr at two", ovr_err, 0);
        send(8'h33, 1'b1);
        check("R4 ovr set", ovr_err, 1);
        check("R4 head kept", rd_data, 8'h11);
        do_pop();
        check("R4 second kept", rd_data, 8'h22);
        do_pop();
        check("R4 third dropped", rd_valid, 0);
        repeat (4) @(negedge clk);
        check("R5 sticky", ovr_err, 1);
        @(negedge clk) clr_ovr = 1'b1;
        @(negedge clk) clr_ovr = 1'b0;
        check("R5 cleared", ovr_err, 0);
    endtask

    task automatic t_ferr();
        send(8'h5A, 1'b0);
        check("R6 stored", rd_valid, 1);
        check("R6 data", rd_data, 8'h5A);
        check("R6 ferr", rd_ferr, 1);
        do_pop();
    endtask

    task automatic t_glitch();
        @(negedge clk) rxd = 1'b0;
        repeat (3 * CLK_DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * BIT) @(negedge clk);
        check("R2 glitch ignored", rd_valid, 0);
        check("R2 rts stays", rts_n, 0);
    endtask

    task automatic t_empty_pop();
        do_pop();
        check("R3 empty pop", rd_valid, 0);
        send(8'hF0, 1'b1);
        check("R3 after empty pop", rd_data, 8'hF0);
        do_pop();
        check("R3 drained again", rd_valid, 0);
    endtask

    task automatic t_paced();
        for (int k = 0; k < 4; k++) begin
            send(8'(k * 37 + 1), 1'b1);
            check("R1 paced data", rd_data, (k * 37 + 1) & 8'hFF);
            do_pop();
        end
        check("R4 paced no ovr", ovr_err, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_single();
        t_order();
        t_overrun();
        t_ferr();
        t_glitch();
        t_empty_pop();
        t_paced();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule